// File: doc/BRIEF.md
# Software-Filled Translation Buffer with Walk Assist

This block is a small fully associative data translation buffer. Software fills it one entry at a time through a narrow register port. Before the commit, software stages the page number, the address space ID and the segment attributes in holding registers. Writing the real page number register then builds an entry from those held values and the written value. The entry goes into the slot that the control register points at. The slot pointer then moves on by itself, round-robin, and skips a low group of slots when software has set them aside.

A lookup port takes an effective address. It compares the address against every slot, using the current address space ID register. One cycle later it returns a hit flag, the translated real address and two attributes. A miss copies the missing page number into the page number register, so a miss handler can read it back.

To speed up a software page-table walk, two registers return computed addresses when the assist mode is on. The level-1 base register returns the address of the first-level table entry. The segment register returns the address of the second-level entry. Both addresses are built from the held page number.

Top module: `soft_tlb`

## Requirements
- R1: After reset the control register reads 0x04000000, so only the assist enable (bit 26) is set, and the lookup outputs hitValid and hit are low.
- R2: Control bits 12:8 hold the slot index that the next commit writes. Software may write any index, including a set-aside slot. A commit replaces the previous entry in that slot.
- R3: After each commit the slot index moves to the next slot and wraps from the last slot to slot 0. When control bit 27 is set, an index that would land in slots 0 to 3 goes to slot 4 instead.
- R4: A write to register code 5 (real page number, page in bits 31:12) commits an entry. The entry takes its page number from bits 31:12 and its ID from bits 3:0 of register code 1, and its attributes from register code 4. The entry can hit only when bit 9 of code 1 and bit 0 of code 4 were both 1 at commit.
- R5: A lookup hits only on an entry whose ID equals bits 3:0 of register code 2.
- R6: Segment bits 3:2 set the page size: 11 is 8 MB, 01 is 512 KB, and 00 (or 10) is a small page. For a small page, bit 3 of the committed value picks 16 KB (1) or 4 KB (0). Address bits inside the page pass from the effective address into the real address; the bits above come from the entry.
- R7: The result of a lookup appears as a one-cycle hitValid pulse on the cycle after lkValid is sampled.
- R8: On a missed lookup, bits 31:12 of register code 1 take the missed address, and bits 9 and 3:0 keep their values.
- R9: With assist on, a read of register code 3 returns its bits 31:12, then held page bits 31:22 in bits 11:2, then zeros in bits 1:0.
- R10: With assist on, a read of register code 4 returns its bits 31:12, then held page bits 21:12 in bits 11:2, then zeros in bits 1:0.
- R11: With assist off (control bit 26 clear), codes 3 and 4 read back exactly the value written.
- R12: On a hit, attrGuarded is segment bit 4 and attrWriteThru is segment bit 1, as held at commit. On a miss, both are 0 and realAddr is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register code (0 control, 1 page number, 2 ID, 3 level-1 base, 4 segment, 5 real page) |
| regWrData | input | 32 | Register write value |
| regRdData | output | 32 | Combinational read of the register selected by regAddr |
| lkValid | input | 1 | Lookup request |
| lkAddr | input | 32 | Effective address to translate |
| hitValid | output | 1 | Lookup result valid, one cycle after the request |
| hit | output | 1 | Lookup found a matching entry |
| realAddr | output | 32 | Translated address, 0 on miss |
| attrGuarded | output | 1 | Guarded attribute of the hit entry |
| attrWriteThru | output | 1 | Write-through attribute of the hit entry |

## Verification
The hardest state to reach from the ports is a set-aside slot being overwritten while the automatic pointer still steers clear of it. The stimulus gets there by committing entries until the pointer is past slot 0. It then sets the reserve bit with an explicit index of 31 to force a wrap, and later writes index 1 directly to replace a live 16 KB entry. Each step is followed by lookups that show which mapping survived and by control reads that show the pointer jumped to slot 4. The page-size masks are covered by addresses near the top of each page, where a wrong mask changes the real address.

// File: rtl/stlb_pkg.sv
package stlb_pkg;

  localparam logic [2:0] ADDR_CTRL   = 3'd0;
  localparam logic [2:0] ADDR_EPN    = 3'd1;
  localparam logic [2:0] ADDR_ASID   = 3'd2;
  localparam logic [2:0] ADDR_L1BASE = 3'd3;
  localparam logic [2:0] ADDR_SEG    = 3'd4;
  localparam logic [2:0] ADDR_RPN    = 3'd5;

  localparam int CTRL_IDX_LSB    = 8;
  localparam int CTRL_RSV_BIT    = 27;
  localparam int CTRL_ASSIST_BIT = 26;
  localparam logic [31:0] CTRL_RESET = 32'h0400_0000;

  // bits kept by the page number register: page, valid flag, ID
  localparam logic [31:0] EPN_KEEP = 32'hFFFF_F20F;

  typedef enum logic [1:0] {
    PG_4K   = 2'd0,
    PG_16K  = 2'd1,
    PG_512K = 2'd2,
    PG_8M   = 2'd3
  } pgSize_e;

  typedef struct packed {
    logic wrCtrl;
    logic wrEpn;
    logic wrAsid;
    logic wrL1;
    logic wrSeg;
    logic wrRpn;
  } strobe_t;

  typedef struct packed {
    logic        vld;
    logic [19:0] vpn;
    logic [3:0]  asid;
    pgSize_e     size;
    logic [19:0] ppn;
    logic        guarded;
    logic        wt;
  } entry_t;

  // page-number bits that come from the effective address for a size
  function automatic logic [19:0] pageMask(input pgSize_e sz);
    case (sz)
      PG_16K:  return 20'h0_0003;
      PG_512K: return 20'h0_007F;
      PG_8M:   return 20'h0_07FF;
      default: return 20'h0_0000;
    endcase
  endfunction

endpackage

// File: rtl/stlb_ctrl.sv
module stlb_ctrl
  import stlb_pkg::*;
#(
  parameter int NUM_SLOTS = 32,
  parameter int RSV_SLOTS = 4,
  parameter int IDX_W     = $clog2(NUM_SLOTS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [2:0]       regAddr,
  input  logic             rsvIn,
  input  logic             assistIn,
  input  logic [IDX_W-1:0] idxIn,
  output strobe_t          strb,
  output logic [IDX_W-1:0] loadIdx,
  output logic             assistOn,
  output logic [31:0]      ctrlWord
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_SLOTS - 1);
  localparam logic [IDX_W-1:0] FIRST_FREE = IDX_W'(RSV_SLOTS);

  logic reserveOn;

  always_comb begin
    strb = '0;
    if (regWrEn) begin
      case (regAddr)
        ADDR_CTRL:   strb.wrCtrl = 1'b1;
        ADDR_EPN:    strb.wrEpn  = 1'b1;
        ADDR_ASID:   strb.wrAsid = 1'b1;
        ADDR_L1BASE: strb.wrL1   = 1'b1;
        ADDR_SEG:    strb.wrSeg  = 1'b1;
        ADDR_RPN:    strb.wrRpn  = 1'b1;
        default:     strb = '0;
      endcase
    end
  end

  function automatic logic [IDX_W-1:0] advanceIdx(input logic [IDX_W-1:0] cur,
                                                  input logic rsv);
    logic [IDX_W-1:0] nxt;
    nxt = (cur == LAST_IDX) ? '0 : cur + 1'b1;
    if (rsv && (nxt < FIRST_FREE)) nxt = FIRST_FREE;
    return nxt;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loadIdx   <= '0;
      reserveOn <= CTRL_RESET[CTRL_RSV_BIT];
      assistOn  <= CTRL_RESET[CTRL_ASSIST_BIT];
    end else if (strb.wrCtrl) begin
      loadIdx   <= idxIn;
      reserveOn <= rsvIn;
      assistOn  <= assistIn;
    end else if (strb.wrRpn) begin
      loadIdx   <= advanceIdx(loadIdx, reserveOn);
    end
  end

  always_comb begin
    ctrlWord = '0;
    ctrlWord[CTRL_RSV_BIT]          = reserveOn;
    ctrlWord[CTRL_ASSIST_BIT]       = assistOn;
    ctrlWord[CTRL_IDX_LSB +: IDX_W] = loadIdx;
  end

  AST_IDX_CLEAR_OF_RSV: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrRpn && reserveOn) |=> (loadIdx >= FIRST_FREE)); // R3

  AST_IDX_MOVES_ON_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrRpn |=> (loadIdx != $past(loadIdx))); // R3

endmodule

// File: rtl/stlb_datapath.sv
module stlb_datapath
  import stlb_pkg::*;
#(
  parameter int NUM_SLOTS = 32,
  parameter int IDX_W     = $clog2(NUM_SLOTS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic [2:0]       regAddr,
  input  logic [31:0]      regWrData,
  input  logic [IDX_W-1:0] loadIdx,
  input  logic             assistOn,
  input  logic [31:0]      ctrlWord,
  input  logic             lkValid,
  input  logic [31:0]      lkAddr,
  output logic [31:0]      regRdData,
  output logic             hitValid,
  output logic             hit,
  output logic [31:0]      realAddr,
  output logic             attrGuarded,
  output logic             attrWriteThru
);

  logic [31:0] epnReg;
  logic [3:0]  asidReg;
  logic [31:0] l1Reg;
  logic [31:0] segReg;
  logic [31:0] rpnReg;

  entry_t slots [NUM_SLOTS];
  entry_t newEnt;

  logic [NUM_SLOTS-1:0] matchVec;
  logic                 anyMatch;
  logic [IDX_W-1:0]     selIdx;
  logic [19:0]          selMask;
  logic [19:0]          selPage;

  // ---------------- held registers ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      epnReg  <= '0;
      asidReg <= '0;
      l1Reg   <= '0;
      segReg  <= '0;
      rpnReg  <= '0;
    end else begin
      if (strb.wrEpn)
        epnReg <= regWrData & EPN_KEEP;
      else if (lkValid && !anyMatch)
        epnReg[31:12] <= lkAddr[31:12];
      if (strb.wrAsid) asidReg <= regWrData[3:0];
      if (strb.wrL1)   l1Reg   <= regWrData;
      if (strb.wrSeg)  segReg  <= regWrData;
      if (strb.wrRpn)  rpnReg  <= regWrData;
    end
  end

  // ---------------- entry build and commit ----------------
  always_comb begin
    newEnt.vld     = epnReg[9] & segReg[0];
    newEnt.vpn     = epnReg[31:12];
    newEnt.asid    = epnReg[3:0];
    newEnt.ppn     = regWrData[31:12];
    newEnt.guarded = segReg[4];
    newEnt.wt      = segReg[1];
    case (segReg[3:2])
      2'b11:   newEnt.size = PG_8M;
      2'b01:   newEnt.size = PG_512K;
      default: newEnt.size = regWrData[3] ? PG_16K : PG_4K;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < NUM_SLOTS; s++) slots[s] <= '0;
    end else if (strb.wrRpn) begin
      slots[loadIdx] <= newEnt;
    end
  end

  // ---------------- associative compare ----------------
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_cmp
    logic [19:0] cmpMask;
    assign cmpMask     = pageMask(slots[s].size);
    assign matchVec[s] = slots[s].vld && (slots[s].asid == asidReg) &&
                         (((slots[s].vpn ^ lkAddr[31:12]) & ~cmpMask) == 20'd0);
  end

  always_comb begin
    selIdx = '0;
    for (int s = NUM_SLOTS - 1; s >= 0; s--) begin
      if (matchVec[s]) selIdx = IDX_W'(s);
    end
  end

  assign anyMatch = |matchVec;
  assign selMask  = pageMask(slots[selIdx].size);
  assign selPage  = (slots[selIdx].ppn & ~selMask) | (lkAddr[31:12] & selMask);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hitValid      <= 1'b0;
      hit           <= 1'b0;
      realAddr      <= '0;
      attrGuarded   <= 1'b0;
      attrWriteThru <= 1'b0;
    end else begin
      hitValid <= lkValid;
      if (lkValid && anyMatch) begin
        hit           <= 1'b1;
        realAddr      <= {selPage, lkAddr[11:0]};
        attrGuarded   <= slots[selIdx].guarded;
        attrWriteThru <= slots[selIdx].wt;
      end else begin
        hit           <= 1'b0;
        realAddr      <= '0;
        attrGuarded   <= 1'b0;
        attrWriteThru <= 1'b0;
      end
    end
  end

  // ---------------- register read with walk assist ----------------
  always_comb begin
    case (regAddr)
      ADDR_CTRL:   regRdData = ctrlWord;
      ADDR_EPN:    regRdData = epnReg;
      ADDR_ASID:   regRdData = {28'd0, asidReg};
      ADDR_L1BASE: regRdData = assistOn ? {l1Reg[31:12], epnReg[31:22], 2'b00} : l1Reg;
      ADDR_SEG:    regRdData = assistOn ? {segReg[31:12], epnReg[21:12], 2'b00} : segReg;
      ADDR_RPN:    regRdData = rpnReg;
      default:     regRdData = '0;
    endcase
  end

  AST_MISS_CAPTURES_PAGE: assert property (@(posedge clk) disable iff (!rstN)
    (hitValid && !hit && !$past(strb.wrEpn)) |-> (epnReg[31:12] == $past(lkAddr[31:12]))); // R8

  AST_OFFSET_PASSES: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> (realAddr[11:0] == $past(lkAddr[11:0]))); // R6

  AST_NO_RESULT_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rstN)
    !hitValid |-> (!hit && !attrGuarded && !attrWriteThru)); // R7

endmodule

// File: rtl/soft_tlb.sv
module soft_tlb
  import stlb_pkg::*;
#(
  parameter int NUM_SLOTS = 32,
  parameter int RSV_SLOTS = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [2:0]  regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  input  logic        lkValid,
  input  logic [31:0] lkAddr,
  output logic        hitValid,
  output logic        hit,
  output logic [31:0] realAddr,
  output logic        attrGuarded,
  output logic        attrWriteThru
);

  localparam int IDX_W = $clog2(NUM_SLOTS);

  strobe_t          strb;
  logic [IDX_W-1:0] loadIdx;
  logic             assistOn;
  logic [31:0]      ctrlWord;

  stlb_ctrl #(
    .NUM_SLOTS(NUM_SLOTS),
    .RSV_SLOTS(RSV_SLOTS),
    .IDX_W    (IDX_W)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .regWrEn  (regWrEn),
    .regAddr  (regAddr),
    .rsvIn    (regWrData[CTRL_RSV_BIT]),
    .assistIn (regWrData[CTRL_ASSIST_BIT]),
    .idxIn    (regWrData[CTRL_IDX_LSB +: IDX_W]),
    .strb     (strb),
    .loadIdx  (loadIdx),
    .assistOn (assistOn),
    .ctrlWord (ctrlWord)
  );

  stlb_datapath #(
    .NUM_SLOTS(NUM_SLOTS),
    .IDX_W    (IDX_W)
  ) dp_i (
    .clk           (clk),
    .rstN          (rstN),
    .strb          (strb),
    .regAddr       (regAddr),
    .regWrData     (regWrData),
    .loadIdx       (loadIdx),
    .assistOn      (assistOn),
    .ctrlWord      (ctrlWord),
    .lkValid       (lkValid),
    .lkAddr        (lkAddr),
    .regRdData     (regRdData),
    .hitValid      (hitValid),
    .hit           (hit),
    .realAddr      (realAddr),
    .attrGuarded   (attrGuarded),
    .attrWriteThru (attrWriteThru)
  );

endmodule

// File: tb/soft_tlb_tb_top.sv
module soft_tlb_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        lkValid = 1'b0;
  logic [31:0] lkAddr = '0;
  logic        hitValid;
  logic        hit;
  logic [31:0] realAddr;
  logic        attrGuarded;
  logic        attrWriteThru;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // expected {hit, realAddr, guarded, writeThru}
  logic [34:0] expQ[$];
  string       tagQ[$];

  always #5 clk = ~clk;

  soft_tlb dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .lkValid(lkValid),
    .lkAddr(lkAddr), .hitValid(hitValid), .hit(hit), .realAddr(realAddr),
    .attrGuarded(attrGuarded), .attrWriteThru(attrWriteThru)
  );

  task automatic check(input string tag, input logic [34:0] act, input logic [34:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    regAddr = a;
    #1;
    check(tag, {3'b0, regRdData}, {3'b0, exp});
  endtask

  task automatic load(input logic [31:0] epn, input logic [31:0] seg, input logic [31:0] rpn);
    wr(3'd1, epn);
    wr(3'd4, seg);
    wr(3'd5, rpn);
  endtask

  // driver: push expectation then issue request
  task automatic doLookup(input logic [31:0] ea, input logic eHit, input logic [31:0] eRa,
                          input logic eG, input logic eW, input string tag);
    expQ.push_back({eHit, eRa, eG, eW});
    tagQ.push_back(tag);
    @(negedge clk);
    lkValid = 1'b1; lkAddr = ea;
    #1;
    check("R7 no early result", {34'd0, hitValid}, 35'd0);
    @(negedge clk);
    lkValid = 1'b0;
  endtask

  // monitor: compare every result with the head of the queue
  always @(negedge clk) begin
    if (rstN && hitValid) begin
      if (expQ.size() == 0) begin
        checks++; failures++;
        $display("FAIL R7 unexpected result actual=%b expected=none", hit);
      end else begin
        logic [34:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(t, {hit, realAddr, attrGuarded, attrWriteThru}, e);
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R7 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    rd(3'd0, 32'h0400_0000, "R1 ctrl reset");
    check("R1 hitValid/hit reset", {33'd0, hitValid, hit}, 35'd0);

    wr(3'd2, 32'h3);
    // slot 0: 4K guarded
    load(32'h1234_5203, 32'h0000_0011, 32'hABCD_E000);
    doLookup(32'h1234_5678, 1, 32'hABCD_E678, 1, 0, "R4 R12 4K hit");
    rd(3'd0, 32'h0400_0100, "R3 index advanced to 1");
    doLookup(32'h1234_6678, 0, 32'h0, 0, 0, "R12 miss zero");
    rd(3'd1, 32'h1234_6203, "R8 miss page captured");
    // R5 ID mismatch
    wr(3'd2, 32'h4);
    doLookup(32'h1234_5678, 0, 32'h0, 0, 0, "R5 id mismatch");
    wr(3'd2, 32'h3);
    // slot 1: 16K write-through
    load(32'h4000_0203, 32'h0000_0003, 32'h8000_0008);
    doLookup(32'h4000_3ABC, 1, 32'h8000_3ABC, 0, 1, "R6 16K top");
    doLookup(32'h4000_4000, 0, 32'h0, 0, 0, "R6 16K outside");
    // slot 2: 512K
    load(32'h0008_0203, 32'h0000_0005, 32'h1000_0000);
    doLookup(32'h000F_1234, 1, 32'h1007_1234, 0, 0, "R6 512K");
    // slot 3: 8M
    load(32'hC000_0203, 32'h0000_000D, 32'h0080_0000);
    doLookup(32'hC07F_FFFC, 1, 32'h00FF_FFFC, 0, 0, "R6 8M");
    // slot 4: page valid clear; slot 5: segment valid clear
    load(32'h7777_7003, 32'h0000_0001, 32'h0100_0000);
    doLookup(32'h7777_7000, 0, 32'h0, 0, 0, "R4 page flag clear");
    load(32'h6666_6203, 32'h0000_0000, 32'h0200_0000);
    doLookup(32'h6666_6000, 0, 32'h0, 0, 0, "R4 segment flag clear");
    rd(3'd0, 32'h0400_0600, "R3 index at 6");
    // reserve on, index 31: wrap skips slots 0..3
    wr(3'd0, 32'h0C00_1F00);
    load(32'h2222_2203, 32'h0000_0001, 32'h3333_3000);
    doLookup(32'h2222_2004, 1, 32'h3333_3004, 0, 0, "R2 slot 31 load");
    rd(3'd0, 32'h0C00_0400, "R3 wrap to first free");
    // explicit set-aside slot 1 replaces the 16K entry
    wr(3'd0, 32'h0C00_0100);
    load(32'h4000_0203, 32'h0000_0001, 32'h5555_5000);
    doLookup(32'h4000_3ABC, 0, 32'h0, 0, 0, "R2 old entry replaced");
    doLookup(32'h4000_0010, 1, 32'h5555_5010, 0, 0, "R2 new entry");
    rd(3'd0, 32'h0C00_0400, "R3 skip from 2 to 4");
    // reserve off: plain wrap
    wr(3'd0, 32'h0400_1F00);
    wr(3'd5, 32'h5555_5000);
    rd(3'd0, 32'h0400_0000, "R3 plain wrap to 0");
    // walk assist
    wr(3'd1, 32'hFFC0_1203);
    wr(3'd3, 32'h00AB_CFFF);
    wr(3'd4, 32'h1234_51ED);
    rd(3'd3, 32'h00AB_CFFC, "R9 level-1 entry address");
    rd(3'd4, 32'h1234_5004, "R10 level-2 entry address");
    wr(3'd0, 32'h0000_0000);
    rd(3'd3, 32'h00AB_CFFF, "R11 level-1 raw");
    rd(3'd4, 32'h1234_51ED, "R11 segment raw");

    repeat (3) @(negedge clk);
    check("R7 all results seen", {3'd0, 32'(expQ.size())}, 35'd0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule